// File: doc/BRIEF.md
# Interrupt Command Register File with Legacy and Extended Views

This block is the register front end of a single local interrupt unit. Software reaches it through a simple one-beat access port: an index, a read/write flag and up to 64 bits of write data. The block keeps the unit's identity, logical-destination, destination-format, error-status and command registers. It returns read data shaped for the addressing view that is active, either the narrow 32-bit legacy view or the wide extended view. Any access the active view forbids comes back as a one-cycle fault, and such an access changes nothing.

A write to the command register, or to the self-interrupt register in the extended view, is turned into an inter-processor interrupt request. The request carries destination, destination mode, delivery mode, vector, trigger and shorthand. It is presented to a downstream resolver on a valid/ready pair and stays there until the resolver takes it. A further command write that arrives while a request is still waiting is held off through the access port's ready signal.

Top module: `intr_cmd_regfile`

## Requirements
- R1: Index 0x02 (identity) reads as the 32-bit hard identity input in the extended view, and as the stored 8-bit identity in bits 31:24 (zeros below) in the legacy view. A legacy write stores write-data bits 31:24 as the 8-bit identity.
- R2: Index 0x0D (logical destination) reads as the full 32-bit stored value in the extended view, and as its low 8 bits placed in bits 31:24 in the legacy view. A legacy write stores write-data bits 31:24, zero-extended.
- R3: Index 0x0E (destination format) reads as the 4-bit model in bits 31:28 with bits 27:0 all ones. A legacy write stores write-data bits 31:28. Any read or write of it in the extended view faults.
- R4: In the extended view, writes to index 0x02, 0x0D and 0x31 (command high) fault. In the legacy view a write to 0x31 stores all 32 low data bits.
- R5: A write to index 0x30 (command low) issues a request with vector = data[7:0], delivery mode = data[10:8], destination mode = data[11], trigger = data[15] and shorthand = data[19:18].
- R6: The command destination is write-data bits 63:32 in the extended view, and those bits are also stored as command high. In the legacy view it is bits 31:24 of the stored command-high register, zero-extended, and write-data bits 63:32 are ignored.
- R7: Index 0x3F (self interrupt) faults on any access in the legacy view. In the extended view a write issues a request with vector = data[7:0], shorthand 1 (self), delivery mode 0, trigger 0, destination mode 0 and destination 0.
- R8: A write to an index outside {0x02, 0x0D, 0x0E, 0x28, 0x30, 0x31, 0x3F} sets bit 7 of the error status, which reads back at index 0x28 in bits 7:0. A write to 0x28 clears it. Reads of such indices return 0 and change nothing.
- R9: Reset sets the destination format to 0xF, the 8-bit identity to the low 8 bits of the hard identity, error status and command registers to 0, and leaves no request pending. It clears the logical destination only when the extended view is off during reset.
- R10: fault_o pulses high for the single cycle after an accepted faulting access. That access changes no register and issues no request.
- R11: ipi_valid_o rises the cycle after an issuing write and stays high, with all request fields unchanged, until a cycle in which ipi_ready_i is high.
- R12: While a request is pending, a write to index 0x30 or 0x3F sees acc_ready_o low and is not accepted. Every other access is always ready.
- R13: rd_valid_o pulses in the cycle after each accepted read, with rd_data_o holding the formatted value (0 when the read faults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode_i | input | 1 | Selects the extended 64-bit view when high |
| hw_id_i | input | 32 | Hard-wired identity of the unit |
| acc_valid_i | input | 1 | Register access request |
| acc_ready_o | output | 1 | Access can be accepted this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_index_i | input | IDX_W | Register index |
| acc_wdata_i | input | 64 | Write data (upper half used only by wide command writes) |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 32 | Formatted read data |
| fault_o | output | 1 | Access fault pulse |
| ipi_valid_o | output | 1 | Interrupt request pending |
| ipi_ready_i | input | 1 | Resolver accepts the request |
| ipi_dest_o | output | 32 | Request destination |
| ipi_dest_mode_o | output | 1 | Request destination mode (0 physical, 1 logical) |
| ipi_deliv_o | output | 3 | Request delivery mode |
| ipi_vector_o | output | 8 | Request vector |
| ipi_trig_o | output | 1 | Request trigger (0 edge, 1 level) |
| ipi_short_o | output | 2 | Request destination shorthand |

## Verification
Each register index is accessed in both views with distinctive data. Patterns such as a command-high byte that differs from the upper write word make it plain whether the destination was taken from the stored register or from the wide write. Faulting writes are followed by reads of the same register and by checks that no request appears, which separates a correct fault from one that also lets the write through. Requests are held back by a stalled resolver while a second command write is attempted, which tells a stall apart from an overwrite or a dropped request. Reset with the extended view on and then off shows whether the logical destination is kept or cleared.

// File: rtl/intr_cmd_pkg.sv
package intr_cmd_pkg;

    localparam int WORD_W = 32;
    localparam int WIDE_W = 2 * WORD_W;
    localparam int VEC_W  = 8;
    localparam int DLV_W  = 3;
    localparam int SH_W   = 2;
    localparam int LID_W  = 8;
    localparam int DFR_W  = 4;

    // Register indices; their values are decoded by software and must not move.
    localparam logic [7:0] IDX_ID     = 8'h02;
    localparam logic [7:0] IDX_LDR    = 8'h0D;
    localparam logic [7:0] IDX_DFR    = 8'h0E;
    localparam logic [7:0] IDX_ESR    = 8'h28;
    localparam logic [7:0] IDX_CMD_LO = 8'h30;
    localparam logic [7:0] IDX_CMD_HI = 8'h31;
    localparam logic [7:0] IDX_SELF   = 8'h3F;

    localparam logic [SH_W-1:0] SH_SELF = 2'b01;

    typedef enum logic [2:0] {
        K_OTHER, K_ID, K_LDR, K_DFR, K_ESR, K_CMD_LO, K_CMD_HI, K_SELF
    } reg_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] dest;
        logic              dest_mode;
        logic [DLV_W-1:0]  deliv;
        logic [VEC_W-1:0]  vector;
        logic              trig;
        logic [SH_W-1:0]   shorthand;
    } ipi_req_t;

    typedef struct packed {
        logic fault;
        logic wr_id;
        logic wr_ldr;
        logic wr_dfr;
        logic clr_esr;
        logic set_esr;
        logic wr_cmd_lo;
        logic wr_cmd_hi;
        logic hi_from_upper;
        logic issue_cmd;
        logic issue_self;
    } reg_action_t;

    function automatic ipi_req_t cmd_to_req(input logic [WORD_W-1:0] lo,
                                            input logic [WORD_W-1:0] dest);
        ipi_req_t r;
        r.dest      = dest;
        r.vector    = lo[7:0];
        r.deliv     = lo[10:8];
        r.dest_mode = lo[11];
        r.trig      = lo[15];
        r.shorthand = lo[19:18];
        return r;
    endfunction

    function automatic ipi_req_t self_to_req(input logic [VEC_W-1:0] vec);
        ipi_req_t r;
        r           = '0;
        r.vector    = vec;
        r.shorthand = SH_SELF;
        return r;
    endfunction

endpackage

// File: rtl/intr_cmd_decode.sv
module intr_cmd_decode
    import intr_cmd_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] index_i,
    input  logic             write_i,
    input  logic             ext_i,
    input  logic             go_i,
    output reg_kind_e        kind_o,
    output reg_action_t      act_o
);

    function automatic logic hit(input logic [IDX_W-1:0] idx, input logic [7:0] ref_idx);
        return idx == IDX_W'(ref_idx);
    endfunction

    always_comb begin
        if      (hit(index_i, IDX_ID))     kind_o = K_ID;
        else if (hit(index_i, IDX_LDR))    kind_o = K_LDR;
        else if (hit(index_i, IDX_DFR))    kind_o = K_DFR;
        else if (hit(index_i, IDX_ESR))    kind_o = K_ESR;
        else if (hit(index_i, IDX_CMD_LO)) kind_o = K_CMD_LO;
        else if (hit(index_i, IDX_CMD_HI)) kind_o = K_CMD_HI;
        else if (hit(index_i, IDX_SELF))   kind_o = K_SELF;
        else                               kind_o = K_OTHER;
    end

    always_comb begin
        act_o = '0;
        if (go_i) begin
            unique case (kind_o)
                K_ID: begin
                    if (write_i) begin
                        if (ext_i) act_o.fault = 1'b1;
                        else       act_o.wr_id = 1'b1;
                    end
                end
                K_LDR: begin
                    if (write_i) begin
                        if (ext_i) act_o.fault  = 1'b1;
                        else       act_o.wr_ldr = 1'b1;
                    end
                end
                K_DFR: begin
                    if (ext_i)        act_o.fault  = 1'b1;
                    else if (write_i) act_o.wr_dfr = 1'b1;
                end
                K_ESR: begin
                    if (write_i) act_o.clr_esr = 1'b1;
                end
                K_CMD_LO: begin
                    if (write_i) begin
                        act_o.wr_cmd_lo     = 1'b1;
                        act_o.issue_cmd     = 1'b1;
                        act_o.wr_cmd_hi     = ext_i;
                        act_o.hi_from_upper = ext_i;
                    end
                end
                K_CMD_HI: begin
                    if (write_i) begin
                        if (ext_i) act_o.fault     = 1'b1;
                        else       act_o.wr_cmd_hi = 1'b1;
                    end
                end
                K_SELF: begin
                    if (!ext_i)       act_o.fault      = 1'b1;
                    else if (write_i) act_o.issue_self = 1'b1;
                end
                default: begin
                    if (write_i) act_o.set_esr = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/intr_cmd_state.sv
module intr_cmd_state
    import intr_cmd_pkg::*;
#(
    parameter int ESR_W       = 8,
    parameter int ESR_ILL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_i,
    input  logic [WORD_W-1:0] hw_id_i,
    input  reg_kind_e         kind_i,
    input  reg_action_t       act_i,
    input  logic [WIDE_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rd_word_o,
    output logic [WORD_W-1:0] cmd_hi_o
);

    localparam int LID_PAD = WORD_W - LID_W;
    localparam int DFR_PAD = WORD_W - DFR_W;
    localparam int ESR_PAD = WORD_W - ESR_W;

    logic [LID_W-1:0]  id_q;
    logic [WORD_W-1:0] ldr_q;
    logic [DFR_W-1:0]  dfr_q;
    logic [ESR_W-1:0]  esr_q;
    logic [WORD_W-1:0] cmd_lo_q;
    logic [WORD_W-1:0] cmd_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q     <= hw_id_i[LID_W-1:0];
            dfr_q    <= '1;
            esr_q    <= '0;
            cmd_lo_q <= '0;
            cmd_hi_q <= '0;
            if (!ext_i) ldr_q <= '0;
        end else begin
            if (act_i.wr_id)  id_q  <= wdata_i[WORD_W-1 -: LID_W];
            if (act_i.wr_ldr) ldr_q <= {{LID_PAD{1'b0}}, wdata_i[WORD_W-1 -: LID_W]};
            if (act_i.wr_dfr) dfr_q <= wdata_i[WORD_W-1 -: DFR_W];
            if (act_i.clr_esr)      esr_q              <= '0;
            else if (act_i.set_esr) esr_q[ESR_ILL_BIT] <= 1'b1;
            if (act_i.wr_cmd_lo) cmd_lo_q <= wdata_i[WORD_W-1:0];
            if (act_i.wr_cmd_hi)
                cmd_hi_q <= act_i.hi_from_upper ? wdata_i[WIDE_W-1:WORD_W]
                                                : wdata_i[WORD_W-1:0];
        end
    end

    always_comb begin
        unique case (kind_i)
            K_ID:     rd_word_o = ext_i ? hw_id_i : {id_q, {LID_PAD{1'b0}}};
            K_LDR:    rd_word_o = ext_i ? ldr_q : {ldr_q[LID_W-1:0], {LID_PAD{1'b0}}};
            K_DFR:    rd_word_o = {dfr_q, {DFR_PAD{1'b1}}};
            K_ESR:    rd_word_o = {{ESR_PAD{1'b0}}, esr_q};
            K_CMD_LO: rd_word_o = cmd_lo_q;
            K_CMD_HI: rd_word_o = cmd_hi_q;
            default:  rd_word_o = '0;
        endcase
    end

    assign cmd_hi_o = cmd_hi_q;

endmodule

// File: rtl/intr_cmd_issue.sv
module intr_cmd_issue
    import intr_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     issue_i,
    input  ipi_req_t req_i,
    input  logic     ready_i,
    output logic     valid_o,
    output ipi_req_t req_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            req_o   <= '0;
        end else if (issue_i) begin
            valid_o <= 1'b1;
            req_o   <= req_i;
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/intr_cmd_regfile.sv
module intr_cmd_regfile
    import intr_cmd_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int ESR_W       = 8,
    parameter int ESR_ILL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode_i,
    input  logic [31:0]       hw_id_i,
    input  logic              acc_valid_i,
    output logic              acc_ready_o,
    input  logic              acc_write_i,
    input  logic [IDX_W-1:0]  acc_index_i,
    input  logic [63:0]       acc_wdata_i,
    output logic              rd_valid_o,
    output logic [31:0]       rd_data_o,
    output logic              fault_o,
    output logic              ipi_valid_o,
    input  logic              ipi_ready_i,
    output logic [31:0]       ipi_dest_o,
    output logic              ipi_dest_mode_o,
    output logic [2:0]        ipi_deliv_o,
    output logic [7:0]        ipi_vector_o,
    output logic              ipi_trig_o,
    output logic [1:0]        ipi_short_o
);

    localparam int LID_PAD = WORD_W - LID_W;

    reg_kind_e         kind;
    reg_action_t       act;
    logic              go;
    logic              is_cmd_wr;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] cmd_hi;
    logic [WORD_W-1:0] cmd_dest;
    ipi_req_t          new_req;
    ipi_req_t          cur_req;

    assign is_cmd_wr   = acc_write_i && (kind == K_CMD_LO || kind == K_SELF);
    assign acc_ready_o = !(acc_valid_i && is_cmd_wr && ipi_valid_o);
    assign go          = acc_valid_i && acc_ready_o;

    intr_cmd_decode #(.IDX_W(IDX_W)) u_decode (
        .index_i (acc_index_i),
        .write_i (acc_write_i),
        .ext_i   (ext_mode_i),
        .go_i    (go),
        .kind_o  (kind),
        .act_o   (act)
    );

    intr_cmd_state #(.ESR_W(ESR_W), .ESR_ILL_BIT(ESR_ILL_BIT)) u_state (
        .clk       (clk),
        .rst       (rst),
        .ext_i     (ext_mode_i),
        .hw_id_i   (hw_id_i),
        .kind_i    (kind),
        .act_i     (act),
        .wdata_i   (acc_wdata_i),
        .rd_word_o (rd_word),
        .cmd_hi_o  (cmd_hi)
    );

    assign cmd_dest = ext_mode_i ? acc_wdata_i[WIDE_W-1:WORD_W]
                                 : {{LID_PAD{1'b0}}, cmd_hi[WORD_W-1 -: LID_W]};
    assign new_req  = act.issue_self ? self_to_req(acc_wdata_i[VEC_W-1:0])
                                     : cmd_to_req(acc_wdata_i[WORD_W-1:0], cmd_dest);

    intr_cmd_issue u_issue (
        .clk     (clk),
        .rst     (rst),
        .issue_i (act.issue_cmd || act.issue_self),
        .req_i   (new_req),
        .ready_i (ipi_ready_i),
        .valid_o (ipi_valid_o),
        .req_o   (cur_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            fault_o    <= 1'b0;
        end else begin
            rd_valid_o <= go && !acc_write_i;
            rd_data_o  <= (go && !acc_write_i && !act.fault) ? rd_word : '0;
            fault_o    <= act.fault;
        end
    end

    assign ipi_dest_o      = cur_req.dest;
    assign ipi_dest_mode_o = cur_req.dest_mode;
    assign ipi_deliv_o     = cur_req.deliv;
    assign ipi_vector_o    = cur_req.vector;
    assign ipi_trig_o      = cur_req.trig;
    assign ipi_short_o     = cur_req.shorthand;

endmodule

// File: rtl/intr_cmd_regfile_chk.sv
module intr_cmd_regfile_chk
    import intr_cmd_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_mode_i,
    input logic             acc_valid_i,
    input logic             acc_ready_o,
    input logic             acc_write_i,
    input logic [IDX_W-1:0] acc_index_i,
    input logic             rd_valid_o,
    input logic [31:0]      rd_data_o,
    input logic             fault_o,
    input logic             ipi_valid_o,
    input logic             ipi_ready_i,
    input logic [31:0]      ipi_dest_o,
    input logic [7:0]       ipi_vector_o,
    input logic [1:0]       ipi_short_o
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_FAULT_FROM_ACCESS: assert property (@(posedge clk) disable iff (rst || !past_ok)
        fault_o |-> $past(acc_valid_i && acc_ready_o)); // R10

    AST_FAULT_NO_ISSUE: assert property (@(posedge clk) disable iff (rst || !past_ok)
        fault_o |-> !(ipi_valid_o && !$past(ipi_valid_o))); // R10

    AST_IPI_HOLD: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (ipi_valid_o && !ipi_ready_i) |=>
            (ipi_valid_o && $stable(ipi_dest_o) && $stable(ipi_vector_o) && $stable(ipi_short_o))); // R11

    AST_CMD_STALL: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (ipi_valid_o && acc_valid_i && acc_write_i && acc_index_i == IDX_W'(IDX_CMD_LO))
            |-> !acc_ready_o); // R12

    AST_SELF_LEGACY_FAULT: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(acc_valid_i && acc_ready_o && !ext_mode_i && acc_index_i == IDX_W'(IDX_SELF))
            |-> fault_o); // R7

    AST_RDVALID_SRC: assert property (@(posedge clk) disable iff (rst || !past_ok)
        rd_valid_o |-> $past(acc_valid_i && acc_ready_o && !acc_write_i)); // R13

    AST_DFR_LOW_ONES: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (rd_valid_o && !fault_o && $past(acc_index_i == IDX_W'(IDX_DFR)))
            |-> (rd_data_o[27:0] == 28'hFFF_FFFF)); // R3

endmodule

bind intr_cmd_regfile intr_cmd_regfile_chk #(.IDX_W(IDX_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .ext_mode_i   (ext_mode_i),
    .acc_valid_i  (acc_valid_i),
    .acc_ready_o  (acc_ready_o),
    .acc_write_i  (acc_write_i),
    .acc_index_i  (acc_index_i),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .fault_o      (fault_o),
    .ipi_valid_o  (ipi_valid_o),
    .ipi_ready_i  (ipi_ready_i),
    .ipi_dest_o   (ipi_dest_o),
    .ipi_vector_o (ipi_vector_o),
    .ipi_short_o  (ipi_short_o)
);

// File: tb/intr_cmd_regfile_tb_top.sv
`timescale 1ns/1ps
module intr_cmd_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext = 1'b0;
    logic [31:0] hw_id = 32'h0001_23A5;
    logic        a_valid = 1'b0;
    logic        a_write = 1'b0;
    logic [5:0]  a_index = '0;
    logic [63:0] a_wdata = '0;
    logic        ipi_ready = 1'b1;

    logic        acc_ready_o, rd_valid_o, fault_o, ipi_valid_o;
    logic [31:0] rd_data_o, ipi_dest_o;
    logic        ipi_dest_mode_o, ipi_trig_o;
    logic [2:0]  ipi_deliv_o;
    logic [7:0]  ipi_vector_o;
    logic [1:0]  ipi_short_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    intr_cmd_regfile dut_i (
        .clk(clk), .rst(rst), .ext_mode_i(ext), .hw_id_i(hw_id),
        .acc_valid_i(a_valid), .acc_ready_o(acc_ready_o), .acc_write_i(a_write),
        .acc_index_i(a_index), .acc_wdata_i(a_wdata),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .fault_o(fault_o),
        .ipi_valid_o(ipi_valid_o), .ipi_ready_i(ipi_ready),
        .ipi_dest_o(ipi_dest_o), .ipi_dest_mode_o(ipi_dest_mode_o),
        .ipi_deliv_o(ipi_deliv_o), .ipi_vector_o(ipi_vector_o),
        .ipi_trig_o(ipi_trig_o), .ipi_short_o(ipi_short_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_id8;
    logic [31:0] m_ldr = '0;
    logic [3:0]  m_dfr;
    logic [7:0]  m_esr;
    logic [31:0] m_lo, m_hi;
    logic        m_pend, m_rdv, m_fault;
    logic [31:0] m_rdd;
    logic [31:0] m_dest;
    logic        m_dm, m_trig;
    logic [2:0]  m_dlv;
    logic [7:0]  m_vec;
    logic [1:0]  m_sh;

    function automatic logic model_ready();
        return !(a_valid && a_write && (a_index == 6'h30 || a_index == 6'h3F) && m_pend);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_id8 = hw_id[7:0]; m_dfr = 4'hF; m_esr = 0; m_lo = 0; m_hi = 0;
            if (!ext) m_ldr = 0;
            m_pend = 0; m_rdv = 0; m_fault = 0; m_rdd = 0;
        end else begin
            logic go, flt;
            logic [31:0] rd;
            go = a_valid && model_ready();
            flt = 0; rd = 0;
            if (m_pend && ipi_ready) m_pend = 0;
            if (go) begin
                case (int'(a_index))
                    'h02: if (a_write) begin if (ext) flt = 1; else m_id8 = a_wdata[31:24]; end
                          else rd = ext ? hw_id : {m_id8, 24'h0};
                    'h0D: if (a_write) begin if (ext) flt = 1; else m_ldr = {24'h0, a_wdata[31:24]}; end
                          else rd = ext ? m_ldr : {m_ldr[7:0], 24'h0};
                    'h0E: if (ext) flt = 1;
                          else if (a_write) m_dfr = a_wdata[31:28];
                          else rd = {m_dfr, 28'hFFF_FFFF};
                    'h28: if (a_write) m_esr = 0; else rd = {24'h0, m_esr};
                    'h30: if (a_write) begin
                              m_dest = ext ? a_wdata[63:32] : {24'h0, m_hi[31:24]};
                              m_lo = a_wdata[31:0];
                              if (ext) m_hi = a_wdata[63:32];
                              m_vec = a_wdata[7:0]; m_dlv = a_wdata[10:8]; m_dm = a_wdata[11];
                              m_trig = a_wdata[15]; m_sh = a_wdata[19:18]; m_pend = 1;
                          end else rd = m_lo;
                    'h31: if (a_write) begin if (ext) flt = 1; else m_hi = a_wdata[31:0]; end
                          else rd = m_hi;
                    'h3F: if (!ext) flt = 1;
                          else if (a_write) begin
                              m_dest = 0; m_vec = a_wdata[7:0]; m_dlv = 0; m_dm = 0;
                              m_trig = 0; m_sh = 2'b01; m_pend = 1;
                          end
                    default: if (a_write) m_esr[7] = 1'b1;
                endcase
            end
            m_rdv = go && !a_write;
            m_fault = flt;
            m_rdd = (go && !a_write && !flt) ? rd : 32'h0;
        end
    end

    task automatic fail_line(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            total++;
            if (fault_o !== m_fault) fail_line("R10", "fault", fault_o, m_fault);
            else if (rd_valid_o !== m_rdv) fail_line("R13", "rd_valid", rd_valid_o, m_rdv);
            else if (m_rdv && rd_data_o !== m_rdd) fail_line("R13", "rd_data", rd_data_o, m_rdd);
            else if (acc_ready_o !== model_ready()) fail_line("R12", "acc_ready", acc_ready_o, model_ready());
            else if (ipi_valid_o !== m_pend) fail_line("R11", "ipi_valid", ipi_valid_o, m_pend);
            else if (m_pend && {ipi_dest_o, ipi_vector_o, ipi_deliv_o, ipi_dest_mode_o, ipi_trig_o, ipi_short_o}
                               !== {m_dest, m_vec, m_dlv, m_dm, m_trig, m_sh})
                fail_line("R11", "ipi_fields", {ipi_dest_o, ipi_vector_o}, {m_dest, m_vec});
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic acc(input logic w, input int idx, input logic [63:0] d);
        a_valid = 1; a_write = w; a_index = idx[5:0]; a_wdata = d;
        #1;
        while (!acc_ready_o) begin @(negedge clk); #1; end
        @(negedge clk);
        a_valid = 0; a_write = 0;
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) fail_line(tag, "directed", act, exp);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        #1;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        do_reset();
        // reset state, legacy view
        chk("R9", ipi_valid_o, 0);
        acc(0, 'h0E, 0); chk("R9", rd_data_o, 32'hFFFF_FFFF);
        acc(0, 'h0D, 0); chk("R9", rd_data_o, 32'h0);
        acc(0, 'h02, 0); chk("R1", rd_data_o, 32'hA500_0000);
        acc(1, 'h02, 64'h3C00_0000); acc(0, 'h02, 0); chk("R1", rd_data_o, 32'h3C00_0000);
        acc(1, 'h0D, 64'h5A12_3456); acc(0, 'h0D, 0); chk("R2", rd_data_o, 32'h5A00_0000);
        acc(1, 'h0E, 64'h0FFF_FFFF); acc(0, 'h0E, 0); chk("R3", rd_data_o, 32'h0FFF_FFFF);
        acc(1, 'h31, 64'h7700_0011); acc(0, 'h31, 0); chk("R4", rd_data_o, 32'h7700_0011);

        // legacy command write, resolver stalled
        ipi_ready = 0;
        acc(1, 'h30, 64'hFFFF_FFFF_0008_8C41);
        chk("R5", {ipi_vector_o, ipi_deliv_o, ipi_dest_mode_o, ipi_trig_o, ipi_short_o},
                  {8'h41, 3'd4, 1'b1, 1'b1, 2'd2});
        chk("R6", ipi_dest_o, 32'h77);
        repeat (3) @(negedge clk); #1;
        chk("R11", {ipi_valid_o, ipi_vector_o}, {1'b1, 8'h41});
        a_valid = 1; a_write = 1; a_index = 6'h30; a_wdata = 64'hDEAD_BEEF_0000_1234;
        #1; chk("R12", acc_ready_o, 0);
        @(negedge clk); #1; chk("R12", {acc_ready_o, ipi_valid_o}, {1'b0, 1'b1});
        ipi_ready = 1;
        acc(1, 'h30, 64'hDEAD_BEEF_0000_1234);
        chk("R6", ipi_dest_o, 32'h77);
        chk("R5", {ipi_vector_o, ipi_deliv_o, ipi_dest_mode_o, ipi_trig_o, ipi_short_o},
                  {8'h34, 3'd2, 1'b0, 1'b0, 2'd0});
        @(negedge clk); #1; chk("R11", ipi_valid_o, 0);

        // self register forbidden in legacy view
        acc(1, 'h3F, 64'h55); chk("R7", {fault_o, ipi_valid_o}, {1'b1, 1'b0});
        @(negedge clk); #1; chk("R10", fault_o, 0);
        acc(0, 'h3F, 0); chk("R7", {fault_o, rd_data_o}, {1'b1, 32'h0});

        // unhandled indices and error status
        acc(1, 'h15, 64'h1); chk("R8", fault_o, 0);
        acc(0, 'h28, 0); chk("R8", rd_data_o, 32'h80);
        acc(0, 'h20, 0); chk("R8", {fault_o, rd_data_o}, {1'b0, 32'h0});
        acc(1, 'h28, 0); acc(0, 'h28, 0); chk("R8", rd_data_o, 32'h0);

        // extended view
        ext = 1;
        acc(0, 'h02, 0); chk("R1", rd_data_o, 32'h0001_23A5);
        acc(0, 'h0D, 0); chk("R2", rd_data_o, 32'h0000_005A);
        acc(0, 'h0E, 0); chk("R3", {fault_o, rd_data_o}, {1'b1, 32'h0});
        acc(1, 'h0E, 64'h0); chk("R3", fault_o, 1);
        acc(1, 'h02, 64'h1100_0000); chk("R4", fault_o, 1);
        acc(1, 'h0D, 64'hEE00_0000); chk("R4", fault_o, 1);
        acc(1, 'h31, 64'h9900_0000); chk("R4", fault_o, 1);
        acc(0, 'h0D, 0); chk("R10", rd_data_o, 32'h0000_005A);
        acc(0, 'h31, 0); chk("R10", rd_data_o, 32'h7700_0011);

        ipi_ready = 0;
        acc(1, 'h30, 64'h0000_0102_0004_0733);
        chk("R6", ipi_dest_o, 32'h102);
        chk("R5", {ipi_vector_o, ipi_deliv_o, ipi_dest_mode_o, ipi_trig_o, ipi_short_o},
                  {8'h33, 3'd7, 1'b0, 1'b0, 2'd1});
        ipi_ready = 1;
        @(negedge clk); #1;
        acc(0, 'h31, 0); chk("R6", rd_data_o, 32'h102);
        ipi_ready = 0;
        acc(1, 'h3F, 64'hFFFF_FFFF_FFFF_FFC7);
        chk("R7", {ipi_dest_o, ipi_vector_o, ipi_deliv_o, ipi_dest_mode_o, ipi_trig_o, ipi_short_o},
                  {32'h0, 8'hC7, 3'd0, 1'b0, 1'b0, 2'd1});
        ipi_ready = 1;
        @(negedge clk); #1;

        // reset while extended: logical destination kept
        do_reset();
        acc(0, 'h0D, 0); chk("R9", rd_data_o, 32'h0000_005A);
        ext = 0;
        acc(0, 'h0E, 0); chk("R9", rd_data_o, 32'hFFFF_FFFF);
        acc(0, 'h02, 0); chk("R9", rd_data_o, 32'hA500_0000);
        acc(0, 'h30, 0); chk("R9", rd_data_o, 32'h0);
        // reset while legacy: logical destination cleared
        do_reset();
        acc(0, 'h0D, 0); chk("R9", rd_data_o, 32'h0);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule